// File: doc/BRIEF.md
# Paged Address Router for Work RAM and ROM

This block sits between a processor's 24-bit byte bus and two storage arrays: a 128 KB work RAM and a 1 MB ROM image. For every access it looks at the 4 KB page that the address falls in, picks RAM, ROM or nothing, and turns the bus address into an offset inside the chosen array. The page decode is purely combinational. The read return path is a small state machine that remembers which target was read, so the byte is handed back on the next cycle.

Work RAM is visible in two places. The two top banks give a linear view of all 128 KB. The first two pages of bank zero give a short view of the first 8 KB. ROM occupies the upper 32 KB half of a group of low banks and of their copies with address bit 23 set. Each bank contributes 32 KB to a linear ROM offset that wraps at the ROM size. Writes that land on ROM or on an unmapped page change nothing, and reads of unmapped pages return zero.

The read state machine has four states. RD_IDLE means no read was issued in the previous cycle. RD_RAM means a RAM read was issued. RD_ROM means a ROM read was issued. RD_OPEN means a read hit an unmapped page. Every cycle the machine moves to the state that matches the current access: a read goes to RD_RAM, RD_ROM or RD_OPEN according to the decoded target, and no read (or a write) goes to RD_IDLE. Reset puts it in RD_IDLE.

Top module: `mem_bank_decoder`

## Requirements
- R1: The target is chosen from address bits 23:12 alone and is shown on `tgt_sel` as exactly one hot bit: bit 0 RAM, bit 1 ROM, bit 2 unmapped.
- R2: Addresses 0x7E0000 to 0x7FFFFF select RAM, and `ram_addr` equals address bits 16:0.
- R3: Addresses 0x000000 to 0x001FFF select RAM with `ram_addr` equal to address bits 12:0 and the upper offset bits zero. The rest of bank zero's lower half is unmapped, and so are the lower halves of all other banks.
- R4: Any address with bit 15 set in banks 0x00 to 0x1F or 0x80 to 0x9F selects ROM. Every other address outside the RAM windows is unmapped.
- R5: The ROM offset is ((bank AND 0x7F) times 0x8000) OR address bits 14:0, masked with 0xFFFFF.
- R6: A write to a ROM page never asserts `ram_we`, and the RAM contents stay unchanged.
- R7: A read of an unmapped page returns 0x00. A write to one asserts no write enable and changes no RAM byte.
- R8: A RAM write takes effect at the clock edge where `cpu_wr` is high. Because the two RAM windows overlap, a byte written through one window reads back through the other.
- R9: Read data for RAM and ROM appears on `cpu_rdata` in the cycle after the read strobe. `cpu_rdata` is 0x00 after reset and in any cycle that follows a cycle with no read.
- R10: When `cpu_wr` and `cpu_rd` are both high, only the write happens. No array read enable is raised, and the next cycle returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 24 | Byte address from the processor |
| cpu_wdata | input | 8 | Write byte |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_rdata | output | 8 | Read byte, one cycle after the strobe |
| tgt_sel | output | 3 | One-hot target: bit 0 RAM, bit 1 ROM, bit 2 unmapped |
| ram_addr | output | 17 | Translated RAM offset |
| ram_wdata | output | 8 | Byte to store in RAM |
| ram_we | output | 1 | RAM write enable |
| ram_re | output | 1 | RAM read enable |
| ram_rdata | input | 8 | RAM byte, registered by the array |
| rom_addr | output | 20 | Translated ROM offset |
| rom_re | output | 1 | ROM read enable |
| rom_rdata | input | 8 | ROM byte, registered by the array |

## Verification
The target select, both translated offsets and the enables are combinational, so the bench reads them 1 ns after it drives an address at the falling edge, within the same cycle. A write reaches the RAM model at the next rising edge. The read byte passes one rising edge through the array register and the return state register, so the bench samples `cpu_rdata` at the next falling edge, before it drives the next access. The idle and write-blocks-read checks sample at that same falling edge, one cycle after the stimulus.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_RAM  = 2'd1,
        TGT_ROM  = 2'd2
    } tgt_e;

    localparam int SEL_RAM  = 0;
    localparam int SEL_ROM  = 1;
    localparam int SEL_NONE = 2;
    localparam int SEL_W    = 3;
endpackage

// File: rtl/mdec_page_map.sv
module mdec_page_map
    import mdec_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int RAM_AW     = 17,
    parameter int ROM_AW     = 20,
    parameter int PAGE_SHIFT = 12,
    parameter int LOW_PAGES  = 2,
    parameter int ROM_BANKS  = 32,
    parameter int RAM_BANK   = 'h7E
) (
    input  logic [ADDR_W-1:0] addr,
    output tgt_e              tgt,
    output logic [RAM_AW-1:0] ram_off,
    output logic [ROM_AW-1:0] rom_off
);
    localparam int PAGE_W  = ADDR_W - PAGE_SHIFT;
    localparam int BANK_W  = ADDR_W - 16;
    localparam int HALF_W  = 15;
    localparam int FOLD_W  = BANK_W - 1 + HALF_W;
    localparam int LOW_W   = PAGE_SHIFT + $clog2(LOW_PAGES);
    localparam logic [BANK_W-1:0] RAM_BANK_V = BANK_W'(RAM_BANK);

    logic [PAGE_W-1:0] page;
    logic [BANK_W-1:0] bank;
    logic              hit_ram_high;
    logic              hit_ram_low;
    logic              hit_rom;
    logic [FOLD_W-1:0] fold;

    assign page = addr[ADDR_W-1:PAGE_SHIFT];
    assign bank = addr[ADDR_W-1:16];

    // Top two banks: full linear view of work RAM.
    assign hit_ram_high = (bank[BANK_W-1:1] == RAM_BANK_V[BANK_W-1:1]);
    // First pages of bank zero: short view of the bottom of work RAM.
    assign hit_ram_low  = (page < PAGE_W'(LOW_PAGES));
    // Upper half of the low banks, ignoring bank bit 7.
    assign hit_rom      = (bank[BANK_W-2:0] < (BANK_W-1)'(ROM_BANKS)) && addr[HALF_W];

    assign fold    = {bank[BANK_W-2:0], addr[HALF_W-1:0]};
    assign rom_off = ROM_AW'(fold);

    always_comb begin
        if (hit_ram_high) begin
            ram_off = addr[RAM_AW-1:0];
        end else begin
            ram_off = RAM_AW'(addr[LOW_W-1:0]);
        end
    end

    always_comb begin
        if (hit_ram_high || hit_ram_low) begin
            tgt = TGT_RAM;
        end else if (hit_rom) begin
            tgt = TGT_ROM;
        end else begin
            tgt = TGT_NONE;
        end
    end
endmodule

// File: rtl/mdec_read_fsm.sv
module mdec_read_fsm
    import mdec_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_go,
    input  tgt_e              tgt,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic [DATA_W-1:0] rdata
);
    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_RAM  = 2'd1,
        RD_ROM  = 2'd2,
        RD_OPEN = 2'd3
    } rd_state_e;

    rd_state_e state_q;
    rd_state_e state_d;

    always_comb begin
        state_d = RD_IDLE;
        if (rd_go) begin
            unique case (tgt)
                TGT_RAM:  state_d = RD_RAM;
                TGT_ROM:  state_d = RD_ROM;
                default:  state_d = RD_OPEN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            RD_RAM:  rdata = ram_rdata;
            RD_ROM:  rdata = rom_rdata;
            RD_OPEN: rdata = '0;
            default: rdata = '0;
        endcase
    end

    AST_RAM_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && tgt == TGT_RAM) |=> (rdata == ram_rdata)); // R9
    AST_ROM_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && tgt == TGT_ROM) |=> (rdata == rom_rdata)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> (rdata == '0)); // R9
endmodule

// File: rtl/mem_bank_decoder.sv
module mem_bank_decoder
    import mdec_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int DATA_W     = 8,
    parameter int RAM_AW     = 17,
    parameter int ROM_AW     = 20,
    parameter int PAGE_SHIFT = 12,
    parameter int LOW_PAGES  = 2,
    parameter int ROM_BANKS  = 32,
    parameter int RAM_BANK   = 'h7E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [SEL_W-1:0]  tgt_sel,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_we,
    output logic              ram_re,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_re,
    input  logic [DATA_W-1:0] rom_rdata
);
    tgt_e tgt;
    logic rd_go;

    mdec_page_map #(
        .ADDR_W    (ADDR_W),
        .RAM_AW    (RAM_AW),
        .ROM_AW    (ROM_AW),
        .PAGE_SHIFT(PAGE_SHIFT),
        .LOW_PAGES (LOW_PAGES),
        .ROM_BANKS (ROM_BANKS),
        .RAM_BANK  (RAM_BANK)
    ) u_map (
        .addr   (cpu_addr),
        .tgt    (tgt),
        .ram_off(ram_addr),
        .rom_off(rom_addr)
    );

    // A write strobe suppresses any read in the same cycle.
    assign rd_go = cpu_rd && !cpu_wr;

    mdec_read_fsm #(
        .DATA_W(DATA_W)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_go    (rd_go),
        .tgt      (tgt),
        .ram_rdata(ram_rdata),
        .rom_rdata(rom_rdata),
        .rdata    (cpu_rdata)
    );

    always_comb begin
        tgt_sel = '0;
        unique case (tgt)
            TGT_RAM: tgt_sel[SEL_RAM]  = 1'b1;
            TGT_ROM: tgt_sel[SEL_ROM]  = 1'b1;
            default: tgt_sel[SEL_NONE] = 1'b1;
        endcase
    end

    assign ram_wdata = cpu_wdata;
    assign ram_we    = cpu_wr && (tgt == TGT_RAM);
    assign ram_re    = rd_go && (tgt == TGT_RAM);
    assign rom_re    = rd_go && (tgt == TGT_ROM);

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tgt_sel) == 1); // R1
    AST_HIGH_RAM_LINEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[ADDR_W-1:RAM_AW] == '1 >> 1) |-> (tgt_sel[SEL_RAM] && ram_addr == cpu_addr[RAM_AW-1:0])); // R2
    AST_LOW_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[ADDR_W-1:13] == '0) |-> (tgt_sel[SEL_RAM] && ram_addr[RAM_AW-1:13] == '0)); // R3
    AST_ROM_UPPER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_sel[SEL_ROM] |-> cpu_addr[15]); // R4
    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !tgt_sel[SEL_RAM]) |-> !ram_we); // R6
    AST_OPEN_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr && tgt_sel[SEL_NONE]) |=> (cpu_rdata == '0)); // R7
    AST_WRITE_BLOCKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |-> (!ram_re && !rom_re)); // R10
endmodule

// File: tb/mem_bank_decoder_test.sv
`timescale 1ns/100ps
module mem_bank_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_rdata;
    logic [2:0]  tgt_sel;
    logic [16:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic        ram_we;
    logic        ram_re;
    logic [7:0]  ram_rdata = '0;
    logic [19:0] rom_addr;
    logic        rom_re;
    logic [7:0]  rom_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mem_bank_decoder uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .tgt_sel(tgt_sel),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_re(ram_re),
        .ram_rdata(ram_rdata), .rom_addr(rom_addr), .rom_re(rom_re), .rom_rdata(rom_rdata)
    );

    // Behavioural storage: sparse RAM, computed ROM image.
    logic [7:0] ram_mem [int];

    function automatic logic [7:0] rom_byte(input logic [19:0] off);
        return off[7:0] ^ {off[19:16], off[11:8]} ^ 8'h3C;
    endfunction

    function automatic logic [7:0] ram_peek(input int off);
        if (ram_mem.exists(off)) return ram_mem[off];
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (ram_re) ram_rdata <= ram_peek(int'(ram_addr));
        if (rom_re) rom_rdata <= rom_byte(rom_addr);
        if (ram_we) ram_mem[int'(ram_addr)] = ram_wdata;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Drive a read; comb outputs captured 1 ns after the falling edge,
    // the returned byte at the following falling edge.
    task automatic do_read(input logic [23:0] a, output logic [2:0] sel,
                           output logic [16:0] ro, output logic [19:0] mo,
                           output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
        #1;
        sel = tgt_sel; ro = ram_addr; mo = rom_addr;
        @(negedge clk);
        d = cpu_rdata;
        cpu_rd = 1'b0;
    endtask

    task automatic do_write(input logic [23:0] a, input logic [7:0] v, output logic we);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = v; cpu_wr = 1'b1; cpu_rd = 1'b0;
        #1;
        we = ram_we;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    // {address, expected one-hot select, expected offset}
    // RAM rows: R2 high banks, R3 low mirror; ROM rows: R4 and R5; none rows: R3/R4 holes.
    localparam int NV = 15;
    localparam logic [46:0] VEC [NV] = '{
        {24'h7E0000, 3'b001, 20'h00000},
        {24'h7FFFFF, 3'b001, 20'h1FFFF},
        {24'h7F1234, 3'b001, 20'h11234},
        {24'h001ABC, 3'b001, 20'h01ABC},
        {24'h000000, 3'b001, 20'h00000},
        {24'h002000, 3'b100, 20'h00000},
        {24'h008000, 3'b010, 20'h00000},
        {24'h1FFFFF, 3'b010, 20'hFFFFF},
        {24'h85ABCD, 3'b010, 20'h2ABCD},
        {24'h9F8001, 3'b010, 20'hF8001},
        {24'h208000, 3'b100, 20'h00000},
        {24'h0F7FFF, 3'b100, 20'h00000},
        {24'h801000, 3'b100, 20'h00000},
        {24'h7D0000, 3'b100, 20'h00000},
        {24'hA08000, 3'b100, 20'h00000}
    };

    initial begin
        #100000;
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        summary();
    end

    initial begin
        logic [2:0]  sel;
        logic [16:0] ro;
        logic [19:0] mo;
        logic [7:0]  d;
        logic        we;

        // Reset state: no read pending, rdata zero (R9).
        repeat (3) @(negedge clk);
        chk("R9 reset rdata", 32'(cpu_rdata), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 rdata after reset", 32'(cpu_rdata), 32'h0);

        // Table walk: routing, offsets and returned byte.
        for (int i = 0; i < NV; i++) begin
            logic [23:0] a;
            logic [2:0]  es;
            logic [19:0] eo;
            {a, es, eo} = VEC[i];
            do_read(a, sel, ro, mo, d);
            chk("R1 target select", 32'(sel), 32'(es));
            if (es == 3'b001) begin
                chk("R2/R3 ram offset", 32'(ro), 32'(eo));
                chk("R9 ram read data", 32'(d), 32'(ram_peek(int'(eo))));
            end else if (es == 3'b010) begin
                chk("R4/R5 rom offset", 32'(mo), 32'(eo));
                chk("R9 rom read data", 32'(d), 32'(rom_byte(eo)));
            end else begin
                chk("R7 unmapped read", 32'(d), 32'h0);
            end
        end

        // R8: write through the high window, read through the low mirror.
        do_write(24'h7E0010, 8'h5A, we);
        chk("R8 ram_we on write", 32'(we), 32'h1);
        do_read(24'h000010, sel, ro, mo, d);
        chk("R8 mirror readback", 32'(d), 32'h5A);
        // R3/R8: low mirror write seen in high window.
        do_write(24'h001FFF, 8'h33, we);
        do_read(24'h7E1FFF, sel, ro, mo, d);
        chk("R3 low-window write via high window", 32'(d), 32'h33);

        // R9: the cycle after a read with no new read returns zero.
        @(negedge clk);
        chk("R9 idle after read", 32'(cpu_rdata), 32'h0);

        // R6: ROM write ignored.
        do_write(24'h008000, 8'h77, we);
        chk("R6 no ram_we on rom write", 32'(we), 32'h0);
        do_read(24'h008000, sel, ro, mo, d);
        chk("R6 rom unchanged", 32'(d), 32'(rom_byte(20'h00000)));
        do_read(24'h7E0000, sel, ro, mo, d);
        chk("R6 ram offset 0 unchanged", 32'(d), 32'h00);

        // R7: unmapped write ignored.
        do_write(24'h7E2000, 8'h11, we);
        do_write(24'h002000, 8'h99, we);
        chk("R7 no ram_we on unmapped write", 32'(we), 32'h0);
        do_read(24'h7E2000, sel, ro, mo, d);
        chk("R7 ram unchanged by unmapped write", 32'(d), 32'h11);

        // R10: write wins over simultaneous read.
        @(negedge clk);
        cpu_addr = 24'h7E0020; cpu_wdata = 8'hC3; cpu_wr = 1'b1; cpu_rd = 1'b1;
        #1;
        chk("R10 ram_re low during write", 32'(ram_re), 32'h0);
        @(negedge clk);
        chk("R10 no read data after write", 32'(cpu_rdata), 32'h0);
        cpu_wr = 1'b0; cpu_rd = 1'b0;
        do_read(24'h000020, sel, ro, mo, d);
        chk("R10 write landed", 32'(d), 32'hC3);

        summary();
    end
endmodule